// File: doc/BRIEF.md
# Timer event flag and interrupt request register

This block gathers the event strobes of a 16-bit timer/counter core into four sticky status flags: overflow, compare channel A, compare channel B and capture. Each flag stays set until software services it, either through a per-flag interrupt-acknowledge strobe or by writing a one to its bit through a small register write port. A separate four-bit enable register, with the same bit layout as the flag byte, gates each flag onto its own interrupt request line.

The waveform-mode input changes where two of the flags get their set events. In the modes where the capture register holds the counter's TOP value, the capture flag follows the "counter reached TOP" strobe and ignores capture events. The overflow flag follows the wrap strobe in the free-running and clear-on-match modes. In every other mode it follows a strobe that the counter core supplies for that mode. Forced-compare strobes share the compare unit's match line but never raise a compare flag.

Top module: `tmr_evt_flags`

## Requirements
- R1: The flag byte holds overflow at bit 0, compare A at bit 1, compare B at bit 2 and capture at bit 5. Bits 3, 4, 6 and 7 always read 0, and writes to them have no effect. The enable byte uses the same positions.
- R2: While reset (rst_n low) is asserted, and directly after it, all four flags and all four enable bits are 0.
- R3: A compare hit (cmp_a_hit or cmp_b_hit high with its force strobe low) raises its flag at the next rising clock edge. The flag is not yet visible in the cycle of the hit.
- R4: A cycle with force_a (force_b) high never sets compare flag A (B), whatever the level of the matching hit input.
- R5: In waveform modes 8, 10, 12 and 14, the capture flag sets on top_hit and ignores capt_evt. In all other modes it sets on capt_evt and ignores top_hit.
- R6: In waveform modes 0, 4 and 12, the overflow flag sets on wrap_ovf and ignores mode_ovf. In all other modes it sets on mode_ovf and ignores wrap_ovf.
- R7: ack bit i (0 overflow, 1 compare A, 2 compare B, 3 capture) clears the matching flag at the next edge.
- R8: A write with wr_addr 0 clears each flag whose bit position in wr_data is 1 and leaves the flags whose bit is 0 unchanged. The flag byte is read combinationally, and a write takes effect at the next edge.
- R9: When a set event and a clear (ack or write-one) for the same flag fall in the same cycle, the flag ends up set.
- R10: A write with wr_addr 1 loads the enable bits from the flag positions of wr_data. irq bit i (same order as ack) equals flag i AND enable i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wave_mode | input | MODE_W (4) | Waveform-generation mode of the counter |
| capt_evt | input | 1 | Capture event strobe |
| top_hit | input | 1 | Counter reached TOP strobe |
| cmp_a_hit | input | 1 | Compare unit A match line |
| cmp_b_hit | input | 1 | Compare unit B match line |
| force_a | input | 1 | Forced compare A strobe |
| force_b | input | 1 | Forced compare B strobe |
| wrap_ovf | input | 1 | Counter wrapped past its maximum |
| mode_ovf | input | 1 | Overflow strobe supplied by the core for the other modes |
| ack | input | 4 | Per-flag interrupt acknowledge (0 ovf, 1 A, 2 B, 3 capture) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the flag byte, 1 selects the enable byte |
| wr_data | input | DATA_W (8) | Write data |
| flag_byte | output | DATA_W (8) | Current flag byte |
| mask_byte | output | DATA_W (8) | Current enable byte |
| irq | output | 4 | Interrupt requests (0 ovf, 1 A, 2 B, 3 capture) |

## Verification
The properties assume that every strobe is a level sampled at the rising edge and that wave_mode only takes values that are encoded in the mode tables. They also assume that a cycle with no set source and no clear leaves a flag where it was. The stimulus drives all inputs on the falling edge and holds them for a full period. It walks the directed cases through the modes named in R5 and R6, and the random phase draws the mode from the full 4-bit range with independent strobes, so coincident set and clear cycles occur often.

// File: rtl/tef_pkg.sv
package tef_pkg;
   // number of event flags handled by the block
   localparam int TEF_NF = 4;
   // flag vector index order, shared by ack, irq and internal vectors
   localparam int TEF_I_OVF  = 0;
   localparam int TEF_I_CMPA = 1;
   localparam int TEF_I_CMPB = 2;
   localparam int TEF_I_CAPT = 3;

   typedef enum logic {
      TEF_SEL_FLAGS = 1'b0,
      TEF_SEL_MASK  = 1'b1
   } tef_sel_e;

   typedef logic [TEF_NF-1:0] tef_vec_t;
endpackage

// File: rtl/tef_src_sel.sv
module tef_src_sel
   import tef_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter logic [(1<<MODE_W)-1:0] ICR_TOP_MODES  = '0,
   parameter logic [(1<<MODE_W)-1:0] WRAP_OVF_MODES = '0
) (
   input  logic [MODE_W-1:0] wave_mode,
   input  logic              capt_evt,
   input  logic              top_hit,
   input  logic              cmp_a_hit,
   input  logic              cmp_b_hit,
   input  logic              force_a,
   input  logic              force_b,
   input  logic              wrap_ovf,
   input  logic              mode_ovf,
   output tef_vec_t          set_vec
);
   logic use_top;
   logic use_wrap;

   // mode tables are flat bit vectors indexed by mode
   assign use_top  = ICR_TOP_MODES[wave_mode];
   assign use_wrap = WRAP_OVF_MODES[wave_mode];

   always_comb begin
      set_vec              = '0;
      set_vec[TEF_I_OVF]   = use_wrap ? wrap_ovf : mode_ovf;
      // a forced compare shares the match line; it is masked here
      set_vec[TEF_I_CMPA]  = cmp_a_hit & ~force_a;
      set_vec[TEF_I_CMPB]  = cmp_b_hit & ~force_b;
      set_vec[TEF_I_CAPT]  = use_top ? top_hit : capt_evt;
   end
endmodule

// File: rtl/tef_flag_bit.sv
module tef_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (set_i)
         q <= 1'b1;   // set has priority so no event is dropped
      else if (clr_i)
         q <= 1'b0;
   end
endmodule

// File: rtl/tef_mask_reg.sv
module tef_mask_reg #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [NF-1:0] d,
   output logic [NF-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
   import tef_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MODE_W   = 4,
   parameter int POS_OVF  = 0,
   parameter int POS_CMPA = 1,
   parameter int POS_CMPB = 2,
   parameter int POS_CAPT = 5,
   parameter logic [(1<<MODE_W)-1:0] ICR_TOP_MODES  = 16'h5500,
   parameter logic [(1<<MODE_W)-1:0] WRAP_OVF_MODES = 16'h1011
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [MODE_W-1:0]     wave_mode,
   input  logic                  capt_evt,
   input  logic                  top_hit,
   input  logic                  cmp_a_hit,
   input  logic                  cmp_b_hit,
   input  logic                  force_a,
   input  logic                  force_b,
   input  logic                  wrap_ovf,
   input  logic                  mode_ovf,
   input  logic [TEF_NF-1:0]     ack,
   input  logic                  wr_en,
   input  logic                  wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     flag_byte,
   output logic [DATA_W-1:0]     mask_byte,
   output logic [TEF_NF-1:0]     irq
);
   localparam int N_MODES = 1 << MODE_W;
   localparam int FLAG_POS [TEF_NF] = '{POS_OVF, POS_CMPA, POS_CMPB, POS_CAPT};
   localparam logic [DATA_W-1:0] USED_BITS =
      (DATA_W'(1) << POS_OVF)  | (DATA_W'(1) << POS_CMPA) |
      (DATA_W'(1) << POS_CMPB) | (DATA_W'(1) << POS_CAPT);

   // elaboration-time parameter checks
   if (DATA_W < TEF_NF) begin : g_bad_width
      $error("tmr_evt_flags: DATA_W must hold all flags");
   end
   if (POS_OVF >= DATA_W || POS_CMPA >= DATA_W ||
       POS_CMPB >= DATA_W || POS_CAPT >= DATA_W) begin : g_bad_pos
      $error("tmr_evt_flags: flag position outside the data word");
   end
   if ($countones(USED_BITS) != TEF_NF) begin : g_dup_pos
      $error("tmr_evt_flags: flag positions must be distinct");
   end
   if (N_MODES > 256) begin : g_bad_mode
      $error("tmr_evt_flags: MODE_W too large for flat mode tables");
   end

   tef_vec_t set_vec;
   tef_vec_t clr_vec;
   tef_vec_t flag_q;
   tef_vec_t mask_q;
   tef_vec_t wr_bits;
   tef_sel_e wr_sel;
   logic     wr_flags;
   logic     wr_mask;
   logic     unused_wr_bits;

   assign wr_sel   = tef_sel_e'(wr_addr);
   assign wr_flags = wr_en && (wr_sel == TEF_SEL_FLAGS);
   assign wr_mask  = wr_en && (wr_sel == TEF_SEL_MASK);
   assign unused_wr_bits = ^(wr_data & ~USED_BITS);

   // gather the flag-position bits of the write word
   for (genvar i = 0; i < TEF_NF; i++) begin : g_wr_pick
      assign wr_bits[i] = wr_data[FLAG_POS[i]];
   end

   tef_src_sel #(
      .MODE_W         (MODE_W),
      .ICR_TOP_MODES  (ICR_TOP_MODES),
      .WRAP_OVF_MODES (WRAP_OVF_MODES)
   ) u_src (
      .wave_mode (wave_mode),
      .capt_evt  (capt_evt),
      .top_hit   (top_hit),
      .cmp_a_hit (cmp_a_hit),
      .cmp_b_hit (cmp_b_hit),
      .force_a   (force_a),
      .force_b   (force_b),
      .wrap_ovf  (wrap_ovf),
      .mode_ovf  (mode_ovf),
      .set_vec   (set_vec)
   );

   assign clr_vec = ack | (wr_flags ? wr_bits : '0);

   for (genvar i = 0; i < TEF_NF; i++) begin : g_flag
      tef_flag_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_vec[i]),
         .clr_i (clr_vec[i]),
         .q     (flag_q[i])
      );
   end

   tef_mask_reg #(.NF(TEF_NF)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_mask),
      .d     (wr_bits),
      .q     (mask_q)
   );

   // scatter vectors back to their byte positions
   always_comb begin
      flag_byte = '0;
      mask_byte = '0;
      for (int i = 0; i < TEF_NF; i++) begin
         flag_byte[FLAG_POS[i]] = flag_q[i];
         mask_byte[FLAG_POS[i]] = mask_q[i];
      end
   end

   assign irq = flag_q & mask_q;
endmodule

// File: rtl/tef_chk.sv
module tef_chk #(
   parameter int DATA_W   = 8,
   parameter int MODE_W   = 4,
   parameter int POS_OVF  = 0,
   parameter int POS_CMPA = 1,
   parameter int POS_CMPB = 2,
   parameter int POS_CAPT = 5,
   parameter logic [(1<<MODE_W)-1:0] ICR_TOP_MODES  = 16'h5500,
   parameter logic [(1<<MODE_W)-1:0] WRAP_OVF_MODES = 16'h1011
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] wave_mode,
   input logic              capt_evt,
   input logic              top_hit,
   input logic              cmp_a_hit,
   input logic              cmp_b_hit,
   input logic              force_a,
   input logic              force_b,
   input logic [3:0]        ack,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] flag_byte,
   input logic [DATA_W-1:0] mask_byte,
   input logic [3:0]        irq
);
   localparam logic [DATA_W-1:0] USED =
      (DATA_W'(1) << POS_OVF)  | (DATA_W'(1) << POS_CMPA) |
      (DATA_W'(1) << POS_CMPB) | (DATA_W'(1) << POS_CAPT);

   logic top_mode;
   assign top_mode = ICR_TOP_MODES[wave_mode];

   assert_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_byte & ~USED) == '0) && ((mask_byte & ~USED) == '0));

   assert_cmp_a_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_a_hit && !force_a) |=> flag_byte[POS_CMPA]);

   assert_force_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (force_a && !flag_byte[POS_CMPA]) |=> !flag_byte[POS_CMPA]);

   assert_force_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (force_b && !flag_byte[POS_CMPB]) |=> !flag_byte[POS_CMPB]);

   assert_capt_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (top_mode && top_hit) |=> flag_byte[POS_CAPT]);

   assert_capt_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!top_mode && capt_evt) |=> flag_byte[POS_CAPT]);

   assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[1] && !(cmp_a_hit && !force_a)) |=> !flag_byte[POS_CMPA]);

   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && wr_data[POS_CMPB] && !(cmp_b_hit && !force_b))
      |=> !flag_byte[POS_CMPB]);

   assert_w0_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && !wr_data[POS_CMPA] && !ack[1] && flag_byte[POS_CMPA])
      |=> flag_byte[POS_CMPA]);

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_b_hit && !force_b && ack[2]) |=> flag_byte[POS_CMPB]);

   assert_mask_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr) |=> (mask_byte == ($past(wr_data) & USED)));

   assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == {flag_byte[POS_CAPT] & mask_byte[POS_CAPT],
              flag_byte[POS_CMPB] & mask_byte[POS_CMPB],
              flag_byte[POS_CMPA] & mask_byte[POS_CMPA],
              flag_byte[POS_OVF]  & mask_byte[POS_OVF]});
endmodule

bind tmr_evt_flags tef_chk #(
   .DATA_W         (DATA_W),
   .MODE_W         (MODE_W),
   .POS_OVF        (POS_OVF),
   .POS_CMPA       (POS_CMPA),
   .POS_CMPB       (POS_CMPB),
   .POS_CAPT       (POS_CAPT),
   .ICR_TOP_MODES  (ICR_TOP_MODES),
   .WRAP_OVF_MODES (WRAP_OVF_MODES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wave_mode (wave_mode),
   .capt_evt  (capt_evt),
   .top_hit   (top_hit),
   .cmp_a_hit (cmp_a_hit),
   .cmp_b_hit (cmp_b_hit),
   .force_a   (force_a),
   .force_b   (force_b),
   .ack       (ack),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .flag_byte (flag_byte),
   .mask_byte (mask_byte),
   .irq       (irq)
);

// File: tb/sim_tmr_evt_flags.sv
module sim_tmr_evt_flags;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] wave_mode = '0;
   logic       capt_evt = 0, top_hit = 0, cmp_a_hit = 0, cmp_b_hit = 0;
   logic       force_a = 0, force_b = 0, wrap_ovf = 0, mode_ovf = 0;
   logic [3:0] ack = '0;
   logic       wr_en = 0, wr_addr = 0;
   logic [7:0] wr_data = '0;
   logic [7:0] flag_byte, mask_byte;
   logic [3:0] irq;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [3:0] ef = '0;   // expected flags, index 0 ovf,1 A,2 B,3 capt
   logic [3:0] em = '0;   // expected enables

   always #10 clk = ~clk;   // 50 MHz

   tmr_evt_flags u0 (
      .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode),
      .capt_evt(capt_evt), .top_hit(top_hit),
      .cmp_a_hit(cmp_a_hit), .cmp_b_hit(cmp_b_hit),
      .force_a(force_a), .force_b(force_b),
      .wrap_ovf(wrap_ovf), .mode_ovf(mode_ovf), .ack(ack),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .flag_byte(flag_byte), .mask_byte(mask_byte), .irq(irq)
   );

   function automatic logic [7:0] lay(input logic [3:0] v);
      return {2'b00, v[3], 2'b00, v[2], v[1], v[0]};
   endfunction

   function automatic logic [3:0] pick(input logic [7:0] d);
      return {d[5], d[2], d[1], d[0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      capt_evt = 0; top_hit = 0; cmp_a_hit = 0; cmp_b_hit = 0;
      force_a = 0; force_b = 0; wrap_ovf = 0; mode_ovf = 0;
      ack = '0; wr_en = 0; wr_addr = 0; wr_data = '0;
   endtask

   // one clock: model next state from the inputs held now, then compare
   task automatic tick(input string tag);
      logic [3:0] s, c, nf, nm;
      s[0] = (wave_mode inside {4'd0, 4'd4, 4'd12}) ? wrap_ovf : mode_ovf;
      s[1] = cmp_a_hit && !force_a;
      s[2] = cmp_b_hit && !force_b;
      s[3] = (wave_mode inside {4'd8, 4'd10, 4'd12, 4'd14}) ? top_hit : capt_evt;
      c = ack | ((wr_en && !wr_addr) ? pick(wr_data) : 4'b0);
      nf = s | (ef & ~c);
      nm = (wr_en && wr_addr) ? pick(wr_data) : em;
      @(posedge clk);
      @(negedge clk);
      ef = nf;
      em = nm;
      check(tag, {8'h0, flag_byte, mask_byte, 4'h0, irq},
                 {8'h0, lay(ef), lay(em), 4'h0, ef & em});
      idle();
   endtask

   task automatic wr(input logic a, input logic [7:0] d, input string tag);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      check("R2 in reset", {flag_byte, mask_byte, 4'h0, irq}, 0);
      rst_n = 1;
      @(negedge clk);
      check("R2 after reset", {flag_byte, mask_byte, 4'h0, irq}, 0);

      // R3: hit not visible in its own cycle, set after the edge
      wave_mode = 4'd0;
      cmp_a_hit = 1;
      #1 check("R3 same cycle", flag_byte, 8'h00);
      tick("R3 cmp A");
      cmp_b_hit = 1;
      tick("R3 cmp B");

      // R8: write-one clears, write-zero keeps
      wr(0, 8'h00, "R8 write zero keeps");
      wr(0, 8'h02, "R8 clear A only");
      wr(0, 8'hFF, "R8 clear all");

      // R4: forced strobes never set
      force_a = 1; cmp_a_hit = 1;
      tick("R4 force A with hit");
      force_b = 1;
      tick("R4 force B alone");
      force_b = 1; cmp_b_hit = 1; force_a = 1;
      tick("R4 force both");

      // R5: capture source per mode
      wave_mode = 4'd0; top_hit = 1;
      tick("R5 top ignored mode0");
      capt_evt = 1;
      tick("R5 capt mode0");
      ack = 4'b1000;
      tick("R7 ack capt");
      wave_mode = 4'd14; capt_evt = 1;
      tick("R5 capt ignored mode14");
      top_hit = 1;
      tick("R5 top mode14");
      wave_mode = 4'd10;
      wr(0, 8'h20, "R8 clear capt");
      top_hit = 1;
      tick("R5 top mode10");
      ack = 4'b1000;
      tick("R7 ack capt again");

      // R6: overflow source per mode
      wave_mode = 4'd0; mode_ovf = 1;
      tick("R6 mode strobe ignored mode0");
      wrap_ovf = 1;
      tick("R6 wrap mode0");
      ack = 4'b0001;
      tick("R7 ack ovf");
      wave_mode = 4'd12; wrap_ovf = 1;
      tick("R6 wrap mode12");
      ack = 4'b0001;
      tick("R7 ack ovf mode12");
      wave_mode = 4'd5; wrap_ovf = 1;
      tick("R6 wrap ignored mode5");
      mode_ovf = 1;
      tick("R6 mode strobe mode5");

      // R9: set wins over clear
      cmp_b_hit = 1; ack = 4'b0100;
      tick("R9 hit vs ack");
      cmp_b_hit = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h04;
      tick("R9 hit vs write-one");
      wave_mode = 4'd0; capt_evt = 1; ack = 4'b1000;
      tick("R9 capt vs ack");

      // R10 / R1: enable register and request gating
      wr(1, 8'hFF, "R1 enable unused bits");
      wr(1, 8'h05, "R10 enable ovf and B");
      cmp_a_hit = 1;
      tick("R10 A set without enable");
      wr(1, 8'h00, "R10 disable all");

      // R1 and all: random traffic compared every clock
      for (int n = 0; n < 400; n++) begin
         logic [31:0] r;
         r = $urandom;
         wave_mode = r[3:0];
         capt_evt = r[4]; top_hit = r[5];
         cmp_a_hit = r[6]; cmp_b_hit = r[7];
         force_a = r[8] & r[9]; force_b = r[10] & r[11];
         wrap_ovf = r[12]; mode_ovf = r[13];
         ack = r[17:14] & r[21:18];
         wr_en = r[22] & r[23]; wr_addr = r[24];
         wr_data = r[31:24];
         tick("R1 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule